// File: doc/BRIEF.md
# Serial Channel Control Register with Enable Sequencing

This block holds the 8-bit control word of one asynchronous serial channel. It sits between the software-facing register bus and a pair of shift engines, one for transmit and one for receive. Software can load the whole word in one write or set and clear single bits. The word is always readable.

From the word, the block derives the signals the engines need. A channel reset follows the power bit. A run strobe is issued per unit, and it asserts only after power and that unit's enable have both been 1 for a full cycle. A one-cycle unit-initialise pulse is issued once the unit's enable has stayed low for a minimum number of base-clock ticks. The frame configuration fields are passed through unchanged.

The block also owns the transmit pin while the channel is powered down. In that state it drives the pin to its idle level, which is high, or low when the invert option is set. While the channel is powered, the pin follows the transmit engine.

Top module: `uart_ctl_seq`

## Requirements
- R1: After a synchronous reset the word reads 0x10. Both run strobes and both initialise pulses are 0. The channel reset output is active (0).
- R2: A byte write loads all 8 bits, and the read port always shows the stored word. The fields are: bit 7 power, bit 6 transmit enable, bit 5 receive enable, bit 4 MSB-first order, bits 3:2 parity select, bit 1 character length, bit 0 stop length.
- R3: A single-bit write changes only the bit chosen by `bit_sel`. When a byte write and a bit write occur in the same cycle, the byte write wins.
- R4: A unit's run strobe asserts on the clock edge after a cycle in which power and that unit's enable were both 1. An enable written together with power, or written while power is 0, therefore asserts the strobe no earlier than two edges after the write.
- R5: A unit's run strobe deasserts on the edge after a cycle in which either power or that unit's enable was 0.
- R6: Each unit counts base ticks (`base_tick`=1) while its enable is 0, and the count restarts whenever the enable is 1. A single-cycle initialise pulse is issued on the edge where the count reaches DIS_TICKS. A re-enable before that point produces no pulse. Out of reset the count is already full, so no pulse follows reset.
- R7: While power is 0, `txd_o` equals the inverse of `tx_invert`. While power is 1, `txd_o` equals `tx_line_i`.
- R8: `chan_rst_n` equals the power bit, so the engines are held in reset while power is 0.
- R9: The configuration outputs always mirror bits 4, 3:2, 1 and 0 of the word, including while a unit is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | Base-clock enable strobe, one cycle per base period |
| wr_byte | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| wr_bit | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Bit index for single-bit write |
| bit_val | input | 1 | Value for single-bit write |
| rd_data | output | 8 | Stored control word |
| tx_invert | input | 1 | Transmit line invert option |
| tx_line_i | input | 1 | Serial output from the transmit engine |
| txd_o | output | 1 | Transmit pin |
| chan_rst_n | output | 1 | Channel reset to engines, active low |
| tx_run | output | 1 | Transmit unit run strobe |
| rx_run | output | 1 | Receive unit run strobe |
| tx_init | output | 1 | Transmit unit initialise pulse |
| rx_init | output | 1 | Receive unit initialise pulse |
| cfg_msb_first | output | 1 | Bit order, 1 = MSB first |
| cfg_parity | output | 2 | Parity select |
| cfg_char_len | output | 1 | Character length select |
| cfg_stop_len | output | 1 | Stop length select |

## Verification
The bench builds the block with the default DIS_TICKS of 2. At that value, random bursts of enable toggling with a sparse base tick regularly hit all three disable windows: a window one tick short of the limit, a window exactly at the limit, and a window longer than the limit, which must not give a second pulse. Directed writes cover power and enable set in one write, clearing an enable before power, and a byte write colliding with a bit write.

// File: rtl/uart_ctl_pkg.sv
// Shared field positions, reset value and config type for the channel control word.
package uart_ctl_pkg;
    localparam int CTL_W    = 8;
    localparam int POS_PWR  = 7;
    localparam int POS_TXE  = 6;
    localparam int POS_RXE  = 5;
    localparam int POS_DIR  = 4;
    localparam int POS_PAR  = 2;
    localparam int POS_CL   = 1;
    localparam int POS_SL   = 0;
    localparam int N_UNITS  = 2;
    localparam logic [CTL_W-1:0] CTL_RESET = 8'h10;

    typedef struct packed {
        logic       msb_first;
        logic [1:0] parity;
        logic       char_len;
        logic       stop_len;
    } frame_cfg_t;
endpackage

// File: rtl/ctl_reg_file.sv
// Control word storage with byte and single-bit write ports.
// Assumes: a byte write and a bit write in the same cycle resolve in favour of the byte.
module ctl_reg_file #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_we,
    input  logic [W-1:0]  byte_wd,
    input  logic          bit_we,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_wd,
    output logic [W-1:0]  ctl_q
);
    // Store the word: byte write first, else a single-bit update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= RST_VAL;
        else if (byte_we)
            ctl_q <= byte_wd;
        else if (bit_we)
            ctl_q[bit_idx] <= bit_wd;
    end

    AST_BYTE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |=> ctl_q == $past(byte_wd)); // R2
    AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !byte_we) |=> ((ctl_q ^ $past(ctl_q)) & ~(W'(1) << $past(bit_idx))) == '0); // R3
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_we && !byte_we) |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/unit_seq.sv
// Per-unit enable sequencer: registers the run strobe behind power and
// emits a one-cycle initialise pulse after DIS_TICKS base ticks with the enable low.
// Assumes: DIS_TICKS >= 1; base_tick is a single-cycle enable.
module unit_seq #(
    parameter int DIS_TICKS = 2,
    localparam int CW = $clog2(DIS_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic pwr_i,
    input  logic en_i,
    output logic run_o,
    output logic init_o
);
    localparam logic [CW-1:0] FULL = CW'(DIS_TICKS);
    localparam logic [CW-1:0] LAST = CW'(DIS_TICKS - 1);

    logic [CW-1:0] low_cnt;

    // Run only after power and enable were both high for a full cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) run_o <= 1'b0;
        else        run_o <= pwr_i & en_i;
    end

    // Count base ticks with the enable low, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                           low_cnt <= FULL;
        else if (en_i)                        low_cnt <= '0;
        else if (base_tick && low_cnt != FULL) low_cnt <= low_cnt + CW'(1);
    end

    // Pulse once on the tick that completes the disable window.
    always_ff @(posedge clk) begin
        if (!rst_n) init_o <= 1'b0;
        else        init_o <= !en_i && base_tick && (low_cnt == LAST);
    end

    AST_RUN_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(pwr_i)); // R4
    AST_RUN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwr_i && en_i) |=> !run_o); // R5
    AST_INIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |=> !init_o); // R6
    AST_INIT_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        init_o |-> !run_o); // R6
endmodule

// File: rtl/uart_ctl_seq.sv
// Channel control register top: word storage, two unit sequencers and
// transmit pin idle forcing while powered down.
// Assumes: engines sample the config fields only at frame start.
module uart_ctl_seq #(
    parameter int DIS_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       wr_byte,
    input  logic [7:0] wr_data,
    input  logic       wr_bit,
    input  logic [2:0] bit_sel,
    input  logic       bit_val,
    output logic [7:0] rd_data,
    input  logic       tx_invert,
    input  logic       tx_line_i,
    output logic       txd_o,
    output logic       chan_rst_n,
    output logic       tx_run,
    output logic       rx_run,
    output logic       tx_init,
    output logic       rx_init,
    output logic       cfg_msb_first,
    output logic [1:0] cfg_parity,
    output logic       cfg_char_len,
    output logic       cfg_stop_len
);
    import uart_ctl_pkg::*;

    logic [CTL_W-1:0]   ctl;
    logic [N_UNITS-1:0] en_vec, run_vec, init_vec;
    frame_cfg_t         cfg;
    logic               pwr;

    ctl_reg_file #(.W(CTL_W), .RST_VAL(CTL_RESET)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .byte_we(wr_byte), .byte_wd(wr_data),
        .bit_we(wr_bit), .bit_idx(bit_sel), .bit_wd(bit_val),
        .ctl_q(ctl)
    );

    // Decode power, unit enables and frame fields from the word.
    always_comb begin
        pwr           = ctl[POS_PWR];
        en_vec[0]     = ctl[POS_TXE];
        en_vec[1]     = ctl[POS_RXE];
        cfg.msb_first = ctl[POS_DIR];
        cfg.parity    = ctl[POS_PAR+1:POS_PAR];
        cfg.char_len  = ctl[POS_CL];
        cfg.stop_len  = ctl[POS_SL];
    end

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        unit_seq #(.DIS_TICKS(DIS_TICKS)) u_seq (
            .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
            .pwr_i(pwr), .en_i(en_vec[u]),
            .run_o(run_vec[u]), .init_o(init_vec[u])
        );
    end

    // Drive outputs; the pin idles at the inverse of the invert option when unpowered.
    always_comb begin
        rd_data       = ctl;
        chan_rst_n    = pwr;
        tx_run        = run_vec[0];
        rx_run        = run_vec[1];
        tx_init       = init_vec[0];
        rx_init       = init_vec[1];
        cfg_msb_first = cfg.msb_first;
        cfg_parity    = cfg.parity;
        cfg_char_len  = cfg.char_len;
        cfg_stop_len  = cfg.stop_len;
        txd_o         = pwr ? tx_line_i : ~tx_invert;
    end

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_rst_n |-> txd_o == !tx_invert); // R7
    AST_PIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst_n |-> txd_o == tx_line_i); // R7
    AST_RUN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_rst_n |=> !tx_run && !rx_run); // R8
endmodule

// File: tb/uart_ctl_seq_test.sv
module uart_ctl_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic base_tick = 0, wr_byte = 0, wr_bit = 0, bit_val = 0, tx_invert = 0, tx_line_i = 0;
    logic [7:0] wr_data = '0;
    logic [2:0] bit_sel = '0;
    logic [7:0] rd_data;
    logic txd_o, chan_rst_n, tx_run, rx_run, tx_init, rx_init;
    logic cfg_msb_first, cfg_char_len, cfg_stop_len;
    logic [1:0] cfg_parity;

    int total = 0, bad = 0;
    logic [7:0] m_reg;
    logic [1:0] m_run, m_init;
    int m_cnt [2];

    always #10 clk = ~clk;

    uart_ctl_seq #(.DIS_TICKS(2)) uut (.*);

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic exp_txd(input logic [7:0] r, input logic inv, input logic line);
        return r[7] ? line : ~inv;
    endfunction

    task automatic check_all();
        chk("R2 rd_data", rd_data, m_reg);
        chk("R4/R5 tx_run", {7'd0, tx_run}, {7'd0, m_run[0]});
        chk("R4/R5 rx_run", {7'd0, rx_run}, {7'd0, m_run[1]});
        chk("R6 tx_init", {7'd0, tx_init}, {7'd0, m_init[0]});
        chk("R6 rx_init", {7'd0, rx_init}, {7'd0, m_init[1]});
        chk("R7 txd_o", {7'd0, txd_o}, {7'd0, exp_txd(m_reg, tx_invert, tx_line_i)});
        chk("R8 chan_rst_n", {7'd0, chan_rst_n}, {7'd0, m_reg[7]});
        chk("R9 cfg", {3'd0, cfg_msb_first, cfg_parity, cfg_char_len, cfg_stop_len}, {3'd0, m_reg[4:0]});
    endtask

    // Apply inputs at the falling edge, model the rising edge, check at the next falling edge.
    task automatic cyc(input logic tk, input logic wb, input logic [7:0] wd,
                       input logic bb, input logic [2:0] bs, input logic bv,
                       input logic inv, input logic line);
        logic [7:0] nreg;
        base_tick = tk; wr_byte = wb; wr_data = wd; wr_bit = bb; bit_sel = bs; bit_val = bv;
        tx_invert = inv; tx_line_i = line;
        @(posedge clk);
        for (int u = 0; u < 2; u++) begin
            logic en;
            en = m_reg[6-u];
            m_run[u]  = m_reg[7] & en;
            m_init[u] = !en && tk && (m_cnt[u] == 1);
            if (en) m_cnt[u] = 0;
            else if (tk && m_cnt[u] != 2) m_cnt[u] = m_cnt[u] + 1;
        end
        nreg = m_reg;
        if (wb) nreg = wd;
        else if (bb) nreg[bs] = bv;
        m_reg = nreg;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle(input logic tk);
        cyc(tk, 0, 8'h00, 0, 3'd0, 0, tx_invert, tx_line_i);
    endtask

    initial begin
        #(20 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_reg = 8'h10; m_run = 0; m_init = 0; m_cnt[0] = 2; m_cnt[1] = 2;
        check_all();                                   // R1 reset state
        chk("R1 reset word", rd_data, 8'h10);
        tx_invert = 1'b1; #1;
        chk("R7 idle low when inverted", {7'd0, txd_o}, 8'h00);
        tx_invert = 1'b0; #1;
        chk("R7 idle high", {7'd0, txd_o}, 8'h01);
        rst_n = 1'b1;
        idle(1); idle(1); idle(1);
        chk("R6 no pulse out of reset", {6'd0, rx_init, tx_init}, 8'h00);
        // R4: power and both enables in one write.
        cyc(0, 1, 8'hE0, 0, 3'd0, 0, 0, 1);
        chk("R4 run waits a cycle", {6'd0, rx_run, tx_run}, 8'h00);
        idle(0);
        chk("R4 run asserted", {6'd0, rx_run, tx_run}, 8'h03);
        // R3: byte wins over bit in the same cycle.
        cyc(0, 1, 8'hEA, 1, 3'd6, 0, 0, 0);
        chk("R3 byte wins", rd_data, 8'hEA);
        // R6: short disable window, no pulse.
        cyc(0, 0, 8'h00, 1, 3'd6, 0, 0, 0);
        idle(1);
        cyc(0, 0, 8'h00, 1, 3'd6, 1, 0, 0);
        chk("R6 short window no pulse", {7'd0, tx_init}, 8'h00);
        // R5/R6: full window gives one pulse.
        cyc(0, 0, 8'h00, 1, 3'd6, 0, 0, 0);
        idle(1);
        chk("R5 tx run dropped", {7'd0, tx_run}, 8'h00);
        idle(1);
        chk("R6 pulse at limit", {7'd0, tx_init}, 8'h01);
        idle(1);
        chk("R6 pulse single", {7'd0, tx_init}, 8'h00);
        // R9: fields follow while running.
        cyc(0, 0, 8'h00, 1, 3'd1, 0, 0, 0);
        chk("R9 char len while running", {7'd0, cfg_char_len}, 8'h00);
        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0] & r[1], r[4:2] == 3'd0, 8'($urandom), r[7:5] < 3'd3,
                r[10:8], r[11], r[12] & r[13] & r[14], r[15]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule